// File: doc/BRIEF.md
# Shift-and-Saturate Unit

This unit takes a 32-bit register operand, applies an optional normalizing shift (logical left or arithmetic right, 0 to 31 places) and then clamps the shifted value to a selectable bit width. The clamp is either signed or unsigned. When the shifted value does not fit the chosen width, the unit replaces it with the nearest representable extreme and raises a saturation indication. That indication also sets a sticky flag that stays high until an explicit clear input is pulsed.

The datapath is one registered stage. An operation presented with `op_valid` high appears on `result` one clock later, together with `res_valid` and the per-operation `sat_hit` pulse. The sticky flag `q_flag` updates on that same edge. A decoder upstream supplies the operand, the shift controls and the width selector. Downstream logic reads the result and folds `q_flag` into a wider status word.

Top module: `sat_shift_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result`, `res_valid`, `sat_hit` and `q_flag` all become 0.
- R2: `shift_kind` = 0 selects a logical left shift of `operand` by `shift_amt`, with bits moved past bit 31 discarded. `shift_kind` = 1 selects an arithmetic right shift by `shift_amt`. The shift is applied before any range test.
- R3: Signed mode (`is_signed` = 1) uses width N = `sat_sel` + 1, from 1 to 32. A shifted value in [-2^(N-1), 2^(N-1)-1] is output unchanged as a 32-bit two's-complement value, and `sat_hit` stays 0.
- R4: In signed mode, a shifted value above 2^(N-1)-1 outputs 2^(N-1)-1, and a value below -2^(N-1) outputs -2^(N-1). Either case sets `sat_hit`.
- R5: Unsigned mode (`is_signed` = 0) uses width N = `sat_sel`, from 0 to 31. A shifted value in [0, 2^N-1] is output zero-extended and unchanged. A larger positive value outputs 2^N-1 and sets `sat_hit`.
- R6: In unsigned mode, a shifted value with bit 31 set (negative) outputs 0 and sets `sat_hit`.
- R7: `result`, `res_valid` and `sat_hit` reflect an operation exactly one clock after the edge that samples `op_valid` high. `sat_hit` is never high without `res_valid`.
- R8: `q_flag` is set on the edge that registers a saturating operation, and it stays set through later non-saturating operations and idle cycles.
- R9: `q_clear` high at an edge clears `q_flag`, unless a saturating operation is registered on that same edge, in which case `q_flag` ends set.
- R10: With `op_valid` low, `result` holds its last value, `res_valid` and `sat_hit` are 0, and `q_flag` changes only through `q_clear`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| operand | input | 32 | Value to shift and clamp |
| shift_kind | input | 1 | 0 = logical left, 1 = arithmetic right |
| shift_amt | input | 5 | Shift distance, 0 to 31 |
| is_signed | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| sat_sel | input | 5 | Width selector (signed N = sat_sel+1, unsigned N = sat_sel) |
| q_clear | input | 1 | Clears the sticky flag |
| result | output | 32 | Clamped result, registered |
| res_valid | output | 1 | `result` holds a new operation |
| sat_hit | output | 1 | The registered operation was clamped |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The range assertions assume that `is_signed` and `sat_sel` are stable and meaningful whenever `op_valid` is high. The checker records them on that edge and judges the next `result` against the width they define. The stimulus changes these controls only at falling edges and always pairs them with `op_valid`. The `q_clear` assertions assume that clearing is a deliberate pulse, so the bench raises it for one cycle at a time, both alone and alongside saturating and non-saturating operations. The sweeps cover every width selector in both modes, with operands placed at each width's extremes and one step beyond them, and every shift distance in both directions.

// File: rtl/satu_pkg.sv
// Shared types for the shift-and-saturate unit.
// Assumes nothing beyond a SystemVerilog compile of this package first.
package satu_pkg;
    typedef enum logic {
        SHIFT_LSL = 1'b0,
        SHIFT_ASR = 1'b1
    } shift_kind_e;
endpackage

// File: rtl/satu_shifter.sv
// Normalizing shifter: logical left or arithmetic right by 0..DATA_W-1.
// Assumes DATA_W is a power of two so that SHAMT_W covers every distance.
module satu_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  din,
    input  satu_pkg::shift_kind_e kind,
    input  logic [SHAMT_W-1:0] amt,
    output logic [DATA_W-1:0]  dout
);
    // Select the shift direction; left shift drops bits past the top.
    always_comb begin
        if (kind == satu_pkg::SHIFT_ASR)
            dout = DATA_W'($signed(din) >>> amt);
        else
            dout = din << amt;
    end
endmodule

// File: rtl/satu_clamp.sv
// Range test and clamp. Signed width is sel+1, unsigned width is sel.
// Assumes the input is a DATA_W-bit two's-complement value.
module satu_clamp #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic              is_signed,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] clamped,
    output logic              sat
);
    logic [DATA_W-1:0] all_ones;
    logic [DATA_W-1:0] s_upper;
    logic [DATA_W-1:0] u_upper;
    logic [DATA_W-1:0] s_min;
    logic [DATA_W-1:0] s_max;
    logic [DATA_W-1:0] u_max;
    logic              s_fits;
    logic              u_fits;

    // Derive the bits above the allowed width and the clamp limits.
    always_comb begin
        all_ones = '1;
        s_upper  = DATA_W'($signed(value) >>> sel);
        u_upper  = value >> sel;
        s_fits   = (s_upper == '0) || (s_upper == all_ones);
        u_fits   = (u_upper == '0);
        s_min    = all_ones << sel;
        s_max    = ~s_min;
        u_max    = ~(all_ones << sel);
    end

    // Pick pass-through or the appropriate limit for the selected mode.
    always_comb begin
        if (is_signed) begin
            sat     = !s_fits;
            clamped = s_fits ? value : (value[DATA_W-1] ? s_min : s_max);
        end else begin
            sat     = !u_fits;
            clamped = u_fits ? value : (value[DATA_W-1] ? '0 : u_max);
        end
    end
endmodule

// File: rtl/satu_qflag.sv
// Sticky saturation flag. A set on the same edge as a clear wins.
// Assumes set is already qualified by a valid operation.
module satu_qflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold, set or clear the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sat_shift_unit.sv
// Shift-and-saturate unit: shift, range test, clamp, then one register
// stage. Assumes control inputs are stable whenever op_valid is high.
module sat_shift_unit #(
    parameter int DATA_W  = 32,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic              shift_kind,
    input  logic [SEL_W-1:0]  shift_amt,
    input  logic              is_signed,
    input  logic [SEL_W-1:0]  sat_sel,
    input  logic              q_clear,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              sat_hit,
    output logic              q_flag
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] clamped;
    logic              sat_now;
    satu_pkg::shift_kind_e kind_e;

    assign kind_e = satu_pkg::shift_kind_e'(shift_kind);

    satu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SEL_W)) u_shift (
        .din  (operand),
        .kind (kind_e),
        .amt  (shift_amt),
        .dout (shifted)
    );

    satu_clamp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_clamp (
        .value     (shifted),
        .is_signed (is_signed),
        .sel       (sat_sel),
        .clamped   (clamped),
        .sat       (sat_now)
    );

    satu_qflag u_qflag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (op_valid && sat_now),
        .clr   (q_clear),
        .flag  (q_flag)
    );

    // Register the result; hold it across idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (op_valid)
            result <= clamped;
    end

    // Register the per-operation valid and saturation pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            sat_hit   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            sat_hit   <= op_valid && sat_now;
        end
    end
endmodule

// Property checker for the shift-and-saturate unit.
// Assumes is_signed and sat_sel are meaningful whenever op_valid is high.
module satu_checker #(
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              is_signed,
    input logic [SEL_W-1:0]  sat_sel,
    input logic              q_clear,
    input logic [DATA_W-1:0] result,
    input logic              res_valid,
    input logic              sat_hit,
    input logic              q_flag
);
    logic              mode_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] r_shr;
    logic [DATA_W-1:0] r_sar;
    logic [DATA_W-1:0] ones;

    // Remember the mode and width of the operation in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            sel_q  <= '0;
        end else if (op_valid) begin
            mode_q <= is_signed;
            sel_q  <= sat_sel;
        end
    end

    // Bits of the output above the width of that operation.
    always_comb begin
        ones  = '1;
        r_shr = result >> sel_q;
        r_sar = DATA_W'($signed(result) >>> sel_q);
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hit |-> res_valid); // R7
    AST_VALID_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R7
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hit |-> q_flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clear) |=> q_flag); // R8
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_clear && !op_valid) |=> !q_flag); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && !sat_hit)); // R10
    AST_SIGNED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode_q) |-> (r_sar == '0 || r_sar == ones)); // R4
    AST_UNSIGNED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mode_q) |-> (r_shr == '0)); // R5
endmodule

bind sat_shift_unit satu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .is_signed (is_signed),
    .sat_sel   (sat_sel),
    .q_clear   (q_clear),
    .result    (result),
    .res_valid (res_valid),
    .sat_hit   (sat_hit),
    .q_flag    (q_flag)
);

// File: tb/tb_sat_shift_unit.sv
module tb_sat_shift_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] operand = '0;
    logic        shift_kind = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic        is_signed = 1'b0;
    logic [4:0]  sat_sel = '0;
    logic        q_clear = 1'b0;
    logic [31:0] result;
    logic        res_valid;
    logic        sat_hit;
    logic        q_flag;

    int checks = 0;
    int fails  = 0;
    bit exp_q  = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2357;

    sat_shift_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .operand(operand),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .is_signed(is_signed),
        .sat_sel(sat_sel), .q_clear(q_clear), .result(result),
        .res_valid(res_valid), .sat_hit(sat_hit), .q_flag(q_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference: shift, then compare with numeric range limits.
    task automatic model(input logic [31:0] op, input logic kind, input logic [4:0] amt,
                         input logic sgn, input logic [4:0] sel,
                         output logic [31:0] r, output bit s, output string tag);
        logic [31:0] t;
        longint v, lo, hi;
        if (kind) t = $signed(op) >>> amt;
        else      t = op << amt;
        v = longint'($signed(t));
        if (sgn) begin
            hi = (64'sd1 <<< sel) - 1;
            lo = -(64'sd1 <<< sel);
        end else begin
            hi = (64'sd1 <<< sel) - 1;
            lo = 0;
        end
        if (v > hi)      begin r = hi[31:0]; s = 1'b1; end
        else if (v < lo) begin r = lo[31:0]; s = 1'b1; end
        else             begin r = t;        s = 1'b0; end
        if (!s)        tag = sgn ? "R3" : "R5";
        else if (sgn)  tag = "R4";
        else           tag = (v < 0) ? "R6" : "R5";
    endtask

    // Drive one cycle at a falling edge, then check at the next one.
    task automatic run_op(input logic [31:0] op, input logic kind, input logic [4:0] amt,
                          input logic sgn, input logic [4:0] sel, input logic clr,
                          input bit shift_tag);
        logic [31:0] er;
        bit es;
        string tg;
        model(op, kind, amt, sgn, sel, er, es, tg);
        if (shift_tag) tg = "R2";
        @(negedge clk);
        op_valid = 1'b1; operand = op; shift_kind = kind; shift_amt = amt;
        is_signed = sgn; sat_sel = sel; q_clear = clr;
        @(negedge clk);
        op_valid = 1'b0; q_clear = 1'b0;
        exp_q = es ? 1'b1 : (clr ? 1'b0 : exp_q);
        check(tg, result, er);
        check("R7 sat_hit", {31'b0, sat_hit}, {31'b0, es});
        check("R7 res_valid", {31'b0, res_valid}, 32'd1);
        check(clr ? "R9" : "R8", {31'b0, q_flag}, {31'b0, exp_q});
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++; checks++;
        $display("FAIL R7 watchdog expired actual=%0d expected=finish", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result, 32'd0);
        check("R1 res_valid", {31'b0, res_valid}, 32'd0);
        check("R1 sat_hit", {31'b0, sat_hit}, 32'd0);
        check("R1 q_flag", {31'b0, q_flag}, 32'd0);
        rst_n = 1'b1;

        // R3..R6: boundary sweep over every width, both modes, no shift
        for (int m = 0; m < 2; m++) begin
            for (int sel = 0; sel < 32; sel++) begin
                longint p = 64'sd1 <<< sel;
                logic [31:0] vals [10];
                vals[0] = 32'(p - 1); vals[1] = 32'(p);
                vals[2] = 32'(p / 2 - 1); vals[3] = 32'(p / 2);
                vals[4] = 32'(-p); vals[5] = 32'(-p - 1);
                vals[6] = 32'd0; vals[7] = 32'hFFFF_FFFF;
                vals[8] = 32'h7FFF_FFFF; vals[9] = 32'h8000_0000;
                for (int k = 0; k < 10; k++)
                    run_op(vals[k], 1'b0, 5'd0, m[0], sel[4:0], 1'b0, 1'b0);
            end
        end

        // R2: every shift distance in both directions, pseudo-random operands
        for (int kd = 0; kd < 2; kd++) begin
            for (int a = 0; a < 32; a++) begin
                for (int k = 0; k < 4; k++) begin
                    lfsr = step(lfsr);
                    run_op(lfsr, kd[0], a[4:0], lfsr[7], lfsr[12:8], 1'b0, 1'b1);
                end
            end
        end

        // R8/R9: sticky behaviour and clear priority
        run_op(32'h0000_0100, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 1'b0); // saturates
        run_op(32'h0000_0001, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 1'b0); // R8 stays set
        @(negedge clk); q_clear = 1'b1;
        @(negedge clk); q_clear = 1'b0; exp_q = 1'b0;
        check("R9 clear alone", {31'b0, q_flag}, 32'd0);
        run_op(32'h0000_0001, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 1'b0); // R8 stays clear
        run_op(32'hFFFF_0000, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 1'b0); // R9 set wins
        run_op(32'h0000_0002, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 1'b0); // R9 clears

        // R10: idle cycles ignore operand changes
        run_op(32'h0000_00FF, 1'b0, 5'd0, 1'b0, 5'd4, 1'b0, 1'b0); // saturates
        hold = result;
        @(negedge clk);
        operand = 32'h1234_5678; is_signed = 1'b1; sat_sel = 5'd2;
        @(negedge clk);
        check("R10 result held", result, hold);
        check("R10 sat_hit", {31'b0, sat_hit}, 32'd0);
        check("R10 res_valid", {31'b0, res_valid}, 32'd0);
        check("R10 q_flag", {31'b0, q_flag}, {31'b0, exp_q});

        // R1: reset mid-run clears the flag and outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 q_flag after reset", {31'b0, q_flag}, 32'd0);
        check("R1 result after reset", result, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule